// File: doc/BRIEF.md
# Predicated Vector Add Sequencer

This block runs one register-to-register add across a vector of up to eight elements, using a small register file that it owns. Each of the three operands has a tag that makes it scalar or vector. The destination is the first operand and the two addends are the other two. A scalar operand names the same register on every element. A vector operand steps one register further for each element. A per-element predicate mask decides which elements produce a sum. A masked element still moves every vector operand on to its next register, so the mask skips results but never skips positions.

The tags select the kind of run. With all three operands scalar, the block does one plain add and ignores the mask. With a vector destination, it walks the full vector length, and a zeroing control decides what a masked element leaves behind: a zero, or the old contents untouched. With a scalar destination and at least one vector addend, it walks the source registers past clear mask bits. At the first set bit it writes a single sum and stops. This lets the mask choose which source element is used. A host port loads and inspects the register file while the sequencer is idle, and the addresses and write strobe the sequencer issues are brought out for observation.

Top module: `pred_vec_add_seq`

## Requirements
- R1: A `start` pulse while idle captures the length, bases, tags, mask and zeroing control, and `busy` rises on the next cycle. One element is handled per busy cycle, at index 0, 1, 2 and so on. A `start` pulse while `busy` is high is ignored.
- R2: An operand tagged scalar (tag bit 0) uses its base register on every element. An operand tagged vector (tag bit 1) uses base plus element index, modulo the register count.
- R3: With all three operands vector, each element i whose mask bit i (bit 0 = element 0) is set writes rs1+rs2, modulo 2^64, to destination register base+i. The run takes exactly `vl` busy cycles.
- R4: In non-zeroing mode (`zero_mode`=0), a masked element writes nothing and leaves its destination register unchanged. The vector operands still advance.
- R5: In zeroing mode (`zero_mode`=1) with a vector destination, a masked element writes zero to its destination register.
- R6: With a scalar destination and at least one vector source, the run steps through elements until the first set mask bit. It writes one sum there and then ends. With no set bit among the first `vl`, it runs `vl` cycles and writes nothing, even in zeroing mode.
- R7: With all three operands scalar, the block does exactly one add and write in one busy cycle, whatever the mask and `vl` are.
- R8: `done` is high for exactly one cycle, the cycle after the last element, and `busy` is low in that cycle. All writes of the run are visible by then.
- R9: With a vector destination and both sources scalar, the same sum is written to successive destination registers, subject to the mask and zeroing rules.
- R10: Register writes are synchronous. A later element reads a value written by an earlier element of the same run.
- R11: A host write (`host_we`) takes effect at the clock edge while the block is idle and is ignored while `busy` is high. `host_rdata` shows register `host_raddr` combinationally.
- R12: After reset, `busy` and `done` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| vl | input | VLW (4) | Vector length, 1 to MAX_VL |
| rd_base | input | AW (5) | Destination base register |
| rs1_base | input | AW (5) | First addend base register |
| rs2_base | input | AW (5) | Second addend base register |
| rd_vec | input | 1 | Destination tag, 1 = vector |
| rs1_vec | input | 1 | First addend tag, 1 = vector |
| rs2_vec | input | 1 | Second addend tag, 1 = vector |
| pred | input | MAX_VL (8) | Element mask, bit i gates element i |
| zero_mode | input | 1 | 1 = masked vector elements are cleared |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | AW (5) | Host write register |
| host_wdata | input | DATA_W (64) | Host write value |
| host_raddr | input | AW (5) | Host read register |
| host_rdata | output | DATA_W (64) | Host read value |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rf_rs1_addr | output | AW (5) | First addend register of current element |
| rf_rs2_addr | output | AW (5) | Second addend register of current element |
| rf_wr_en | output | 1 | Sequencer write strobe |
| rf_wr_addr | output | AW (5) | Sequencer write register |
| rf_wr_data | output | DATA_W (64) | Sequencer write value (sum or zero) |

## Verification
The assertions assume that `vl` lies between 1 and MAX_VL whenever `start` is accepted. They also assume that a run is never entered with `busy` already high, so one run cannot merge into the next. The random stimulus draws the length from that range only, and it pulses `start` while busy only in the directed case that checks the pulse is ignored. Host writes happen only while idle, except for the one directed case that shows such a write is dropped.

// File: rtl/pvs_pkg.sv
`timescale 1ns/1ps
package pvs_pkg;

   typedef enum logic {
      TAG_SCALAR = 1'b0,
      TAG_VECTOR = 1'b1
   } tag_e;

   // operand slots: destination first, then the two addends
   localparam int OPND_RD  = 0;
   localparam int OPND_RS1 = 1;
   localparam int OPND_RS2 = 2;
   localparam int NUM_OPND = 3;

endpackage

// File: rtl/pvs_regfile.sv
`timescale 1ns/1ps
module pvs_regfile #(
   parameter int NUM_REGS  = 32,
   parameter int DATA_W    = 64,
   parameter int NUM_RD    = 3,
   parameter bit RESET_CLR = 1'b1,
   localparam int AW       = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr [NUM_RD],
   output logic [DATA_W-1:0] rdata [NUM_RD]
);

   logic [DATA_W-1:0] mem [NUM_REGS];

   generate
      if (RESET_CLR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int r = 0; r < NUM_REGS; r++) mem[r] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
         assign rdata[p] = mem[raddr[p]];
      end
   endgenerate

endmodule

// File: rtl/pvs_opnd_addr.sv
`timescale 1ns/1ps
module pvs_opnd_addr
   import pvs_pkg::*;
#(
   parameter int AW   = 5,
   parameter int IDXW = 3
) (
   input  logic [AW-1:0]   base,
   input  tag_e            tag,
   input  logic [IDXW-1:0] idx,
   output logic [AW-1:0]   addr
);

   logic [AW-1:0] step;

   always_comb begin
      step = (tag == TAG_VECTOR) ? AW'(idx) : '0;
      addr = base + step;
   end

endmodule

// File: rtl/pvs_ctrl.sv
`timescale 1ns/1ps
module pvs_ctrl
   import pvs_pkg::*;
#(
   parameter int AW     = 5,
   parameter int MAX_VL = 8,
   parameter int VLW    = 4,
   parameter int IDXW   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VLW-1:0]    vl,
   input  logic [AW-1:0]     base_in [NUM_OPND],
   input  tag_e              tag_in  [NUM_OPND],
   input  logic [MAX_VL-1:0] pred,
   input  logic              zero_in,
   output logic              busy,
   output logic              done,
   output logic [IDXW-1:0]   idx,
   output logic [AW-1:0]     base_q  [NUM_OPND],
   output tag_e              tag_q   [NUM_OPND],
   output logic              elem_on,
   output logic              zero_q,
   output logic              wr_en
);

   logic              busy_q;
   logic              done_q;
   logic [IDXW-1:0]   idx_q;
   logic [VLW-1:0]    vl_q;
   logic [MAX_VL-1:0] pred_q;
   logic              accept;
   logic              all_scalar;
   logic              rd_vec;
   logic              last;

   assign accept = start & ~busy_q;

   always_comb begin
      all_scalar = 1'b1;
      for (int k = 0; k < NUM_OPND; k++)
         if (tag_q[k] == TAG_VECTOR) all_scalar = 1'b0;
   end

   assign rd_vec  = (tag_q[OPND_RD] == TAG_VECTOR);
   assign elem_on = all_scalar | pred_q[idx_q];
   assign last    = all_scalar
                  | (~rd_vec & elem_on)
                  | (idx_q == IDXW'(MAX_VL - 1))
                  | ((VLW'(idx_q) + VLW'(1)) == vl_q);
   assign wr_en   = busy_q & (elem_on | (zero_q & rd_vec));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
         vl_q   <= '0;
         pred_q <= '0;
         zero_q <= 1'b0;
         for (int k = 0; k < NUM_OPND; k++) begin
            base_q[k] <= '0;
            tag_q[k]  <= TAG_SCALAR;
         end
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            vl_q   <= vl;
            pred_q <= pred;
            zero_q <= zero_in;
            for (int k = 0; k < NUM_OPND; k++) begin
               base_q[k] <= base_in[k];
               tag_q[k]  <= tag_in[k];
            end
         end else if (busy_q) begin
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx_q <= idx_q + IDXW'(1);
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign idx  = idx_q;

endmodule

// File: rtl/pred_vec_add_seq.sv
`timescale 1ns/1ps
module pred_vec_add_seq
   import pvs_pkg::*;
#(
   parameter int NUM_REGS  = 32,
   parameter int DATA_W    = 64,
   parameter int MAX_VL    = 8,
   parameter bit RESET_CLR = 1'b1,
   localparam int AW       = $clog2(NUM_REGS),
   localparam int VLW      = $clog2(MAX_VL + 1),
   localparam int IDXW     = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VLW-1:0]    vl,
   input  logic [AW-1:0]     rd_base,
   input  logic [AW-1:0]     rs1_base,
   input  logic [AW-1:0]     rs2_base,
   input  logic              rd_vec,
   input  logic              rs1_vec,
   input  logic              rs2_vec,
   input  logic [MAX_VL-1:0] pred,
   input  logic              zero_mode,
   input  logic              host_we,
   input  logic [AW-1:0]     host_waddr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [AW-1:0]     host_raddr,
   output logic [DATA_W-1:0] host_rdata,
   output logic              busy,
   output logic              done,
   output logic [AW-1:0]     rf_rs1_addr,
   output logic [AW-1:0]     rf_rs2_addr,
   output logic              rf_wr_en,
   output logic [AW-1:0]     rf_wr_addr,
   output logic [DATA_W-1:0] rf_wr_data
);

   // elaboration-time parameter checks
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_nregs
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (MAX_VL < 1 || MAX_VL > NUM_REGS) begin : g_bad_vl
      $error("MAX_VL must lie between 1 and NUM_REGS");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be positive");
   end

   logic [AW-1:0]     base_in [NUM_OPND];
   tag_e              tag_in  [NUM_OPND];
   logic [AW-1:0]     base_q  [NUM_OPND];
   tag_e              tag_q   [NUM_OPND];
   logic [AW-1:0]     op_addr [NUM_OPND];
   logic [IDXW-1:0]   seq_idx;
   logic              seq_elem_on;
   logic              seq_zero;
   logic              seq_wr_en;
   logic              seq_busy;
   logic [AW-1:0]     rf_raddr [3];
   logic [DATA_W-1:0] rf_rdata [3];
   logic              rf_we;
   logic [AW-1:0]     rf_waddr;
   logic [DATA_W-1:0] rf_wdata;
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] seq_wdata;

   always_comb begin
      base_in[OPND_RD]  = rd_base;
      base_in[OPND_RS1] = rs1_base;
      base_in[OPND_RS2] = rs2_base;
      tag_in[OPND_RD]   = tag_e'(rd_vec);
      tag_in[OPND_RS1]  = tag_e'(rs1_vec);
      tag_in[OPND_RS2]  = tag_e'(rs2_vec);
   end

   pvs_ctrl #(
      .AW(AW), .MAX_VL(MAX_VL), .VLW(VLW), .IDXW(IDXW)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .vl      (vl),
      .base_in (base_in),
      .tag_in  (tag_in),
      .pred    (pred),
      .zero_in (zero_mode),
      .busy    (seq_busy),
      .done    (done),
      .idx     (seq_idx),
      .base_q  (base_q),
      .tag_q   (tag_q),
      .elem_on (seq_elem_on),
      .zero_q  (seq_zero),
      .wr_en   (seq_wr_en)
   );

   generate
      for (genvar g = 0; g < NUM_OPND; g++) begin : g_addr
         pvs_opnd_addr #(.AW(AW), .IDXW(IDXW)) u_addr (
            .base (base_q[g]),
            .tag  (tag_q[g]),
            .idx  (seq_idx),
            .addr (op_addr[g])
         );
      end
   endgenerate

   always_comb begin
      rf_raddr[0] = op_addr[OPND_RS1];
      rf_raddr[1] = op_addr[OPND_RS2];
      rf_raddr[2] = host_raddr;
   end

   assign sum       = rf_rdata[0] + rf_rdata[1];
   assign seq_wdata = seq_elem_on ? sum : '0;

   // the sequencer owns the write port while a run is in progress
   always_comb begin
      if (seq_wr_en) begin
         rf_we    = 1'b1;
         rf_waddr = op_addr[OPND_RD];
         rf_wdata = seq_wdata;
      end else begin
         rf_we    = host_we & ~seq_busy;
         rf_waddr = host_waddr;
         rf_wdata = host_wdata;
      end
   end

   pvs_regfile #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(3), .RESET_CLR(RESET_CLR)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .waddr (rf_waddr),
      .wdata (rf_wdata),
      .raddr (rf_raddr),
      .rdata (rf_rdata)
   );

   assign host_rdata  = rf_rdata[2];
   assign busy        = seq_busy;
   assign rf_rs1_addr = op_addr[OPND_RS1];
   assign rf_rs2_addr = op_addr[OPND_RS2];
   assign rf_wr_en    = seq_wr_en;
   assign rf_wr_addr  = op_addr[OPND_RD];
   assign rf_wr_data  = seq_wdata;

endmodule

// File: rtl/pvs_checker.sv
`timescale 1ns/1ps
module pvs_checker #(
   parameter int AW     = 5,
   parameter int MAX_VL = 8,
   parameter int VLW    = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [VLW-1:0] vl,
   input logic           busy,
   input logic           done,
   input logic           wr_en,
   input logic [AW-1:0]  rs1_addr,
   input logic [AW-1:0]  rs2_addr,
   input logic           rd_is_vec,
   input logic           rs1_is_vec,
   input logic           rs2_is_vec,
   input logic           all_scalar,
   input logic           elem_on,
   input logic           zero_on
);

   // R1
   vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |-> (vl >= VLW'(1) && vl <= VLW'(MAX_VL)));

   // R1
   idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_en);

   // R2
   rs1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && rs1_is_vec) |-> (rs1_addr == $past(rs1_addr) + AW'(1)));

   // R2
   rs2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !rs2_is_vec) |-> $stable(rs2_addr));

   // R4
   mask_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !elem_on && !zero_on) |-> !wr_en);

   // R6
   scalar_dst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_is_vec && wr_en) |=> !busy);

   // R6
   scalar_dst_nozero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_is_vec && !elem_on) |-> !wr_en);

   // R7
   all_scalar_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && all_scalar) |-> (wr_en ##1 !busy));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R8
   busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind pred_vec_add_seq pvs_checker #(.AW(AW), .MAX_VL(MAX_VL), .VLW(VLW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .vl         (vl),
   .busy       (busy),
   .done       (done),
   .wr_en      (rf_wr_en),
   .rs1_addr   (rf_rs1_addr),
   .rs2_addr   (rf_rs2_addr),
   .rd_is_vec  (tag_q[0] == pvs_pkg::TAG_VECTOR),
   .rs1_is_vec (tag_q[1] == pvs_pkg::TAG_VECTOR),
   .rs2_is_vec (tag_q[2] == pvs_pkg::TAG_VECTOR),
   .all_scalar (tag_q[0] == pvs_pkg::TAG_SCALAR && tag_q[1] == pvs_pkg::TAG_SCALAR &&
                tag_q[2] == pvs_pkg::TAG_SCALAR),
   .elem_on    (seq_elem_on),
   .zero_on    (seq_zero)
);

// File: tb/pred_vec_add_seq_tb.sv
`timescale 1ns/1ps
module pred_vec_add_seq_tb;

   localparam int NREG = 32;
   localparam int DW   = 64;
   localparam int MVL  = 8;
   localparam int AW   = 5;
   localparam int VLW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [VLW-1:0] vl = '0;
   logic [AW-1:0] rd_base = '0, rs1_base = '0, rs2_base = '0;
   logic          rd_vec = 1'b0, rs1_vec = 1'b0, rs2_vec = 1'b0;
   logic [MVL-1:0] pred = '0;
   logic          zero_mode = 1'b0;
   logic          host_we = 1'b0;
   logic [AW-1:0] host_waddr = '0, host_raddr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          busy, done, rf_wr_en;
   logic [AW-1:0] rf_rs1_addr, rf_rs2_addr, rf_wr_addr;
   logic [DW-1:0] rf_wr_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [DW-1:0] mdl [NREG];

   always #2 clk = ~clk;

   pred_vec_add_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
      .rd_base(rd_base), .rs1_base(rs1_base), .rs2_base(rs2_base),
      .rd_vec(rd_vec), .rs1_vec(rs1_vec), .rs2_vec(rs2_vec),
      .pred(pred), .zero_mode(zero_mode),
      .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
      .host_raddr(host_raddr), .host_rdata(host_rdata),
      .busy(busy), .done(done),
      .rf_rs1_addr(rf_rs1_addr), .rf_rs2_addr(rf_rs2_addr),
      .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic host_write(input int a, input logic [DW-1:0] d);
      host_we = 1'b1; host_waddr = AW'(a); host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
      mdl[a] = d;
   endtask

   task automatic load_rf();
      for (int r = 0; r < NREG; r++) host_write(r, {$urandom, $urandom});
   endtask

   // reference model of one run; returns expected busy cycles
   function automatic int model_run(input int n, input int db, input int ab, input int bb,
                                    input bit dv, input bit av, input bit bv,
                                    input logic [MVL-1:0] pm, input bit zm);
      int cyc = 0;
      if (!dv && !av && !bv) begin
         mdl[db] = mdl[ab] + mdl[bb];
         return 1;
      end
      for (int i = 0; i < n; i++) begin
         int d = (db + (dv ? i : 0)) & (NREG - 1);
         int a = (ab + (av ? i : 0)) & (NREG - 1);
         int b = (bb + (bv ? i : 0)) & (NREG - 1);
         cyc++;
         if (pm[i]) begin
            mdl[d] = mdl[a] + mdl[b];
            if (!dv) break;
         end else if (zm && dv) begin
            mdl[d] = '0;
         end
      end
      return cyc;
   endfunction

   // inj: 0 none, 1 start pulse while busy, 2 host write while busy
   task automatic run_op(input string req, input int n, input int db, input int ab,
                         input int bb, input bit dv, input bit av, input bit bv,
                         input logic [MVL-1:0] pm, input bit zm, input int inj);
      int exp_cyc;
      int cnt = 0;
      int guard = 0;
      int bad = 0;
      int bad_r = 0;
      logic [DW-1:0] bad_a = '0, bad_e = '0;
      exp_cyc = model_run(n, db, ab, bb, dv, av, bv, pm, zm);
      vl = VLW'(n); rd_base = AW'(db); rs1_base = AW'(ab); rs2_base = AW'(bb);
      rd_vec = dv; rs1_vec = av; rs2_vec = bv; pred = pm; zero_mode = zm;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R1", "busy after start", {63'd0, busy}, 64'd1);
      while (done !== 1'b1 && guard < 40) begin
         if (busy) cnt++;
         if (cnt == 1 && inj == 1) begin
            start = 1'b1; vl = VLW'(MVL); rd_vec = 1'b1; rs1_vec = 1'b1;
            rs2_vec = 1'b1; pred = '1; zero_mode = 1'b1; rd_base = 5'd0;
         end else start = 1'b0;
         if (cnt == 1 && inj == 2) begin
            host_we = 1'b1; host_waddr = 5'd31; host_wdata = ~mdl[31];
         end else host_we = 1'b0;
         guard++;
         @(negedge clk);
      end
      start = 1'b0; host_we = 1'b0;
      check(cnt == exp_cyc, req, "busy cycles", DW'(cnt), DW'(exp_cyc));
      check(busy === 1'b0 && done === 1'b1, "R8", "busy low with done",
            {62'd0, busy, done}, 64'd1);
      @(negedge clk);
      check(done === 1'b0, "R8", "done one cycle", {63'd0, done}, 64'd0);
      for (int r = 0; r < NREG; r++) begin
         host_raddr = AW'(r);
         #0.1;
         if (host_rdata !== mdl[r]) begin
            if (bad == 0) begin bad_r = r; bad_a = host_rdata; bad_e = mdl[r]; end
            bad++;
         end
      end
      check(bad == 0, req, $sformatf("register %0d after run", bad_r), bad_a, bad_e);
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20201225));
      for (int r = 0; r < NREG; r++) mdl[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check(busy === 1'b0 && done === 1'b0, "R12", "busy/done after reset",
            {62'd0, busy, done}, 64'd0);
      host_raddr = 5'd7; #0.1;
      check(host_rdata === '0, "R12", "register 7 after reset", host_rdata, 64'd0);
      @(negedge clk);

      // R11 host write then read
      host_write(9, 64'hDEAD_BEEF_0123_4567);
      host_raddr = 5'd9; #0.1;
      check(host_rdata === 64'hDEAD_BEEF_0123_4567, "R11", "host write/read",
            host_rdata, 64'hDEAD_BEEF_0123_4567);
      @(negedge clk);
      load_rf();

      run_op("R3", 8, 16, 0, 8, 1, 1, 1, 8'b1011_0110, 0, 0);  // R3 R4
      run_op("R4", 8, 16, 0, 8, 1, 1, 1, 8'b0100_1001, 0, 0);
      run_op("R5", 8, 16, 0, 8, 1, 1, 1, 8'b0100_1001, 1, 0);
      run_op("R6", 8, 24, 0, 8, 0, 1, 1, 8'b0001_0000, 1, 0);  // stops at element 4
      run_op("R6", 6, 24, 2, 10, 0, 1, 0, 8'b1100_0000, 1, 0); // no set bit in 6
      run_op("R7", 8, 3, 5, 6, 0, 0, 0, 8'b0000_0000, 1, 0);
      run_op("R9", 5, 11, 1, 2, 1, 0, 0, 8'b1111_1011, 0, 0);
      run_op("R10", 4, 4, 3, 0, 1, 1, 0, 8'b0000_1111, 0, 0);  // chained
      run_op("R2", 4, 30, 29, 28, 1, 1, 1, 8'b0000_1111, 0, 0); // wrap
      run_op("R1", 3, 12, 0, 1, 1, 1, 1, 8'b0000_0101, 0, 1);  // start ignored
      run_op("R11", 3, 12, 0, 1, 1, 1, 1, 8'b0000_0111, 0, 2); // host write dropped

      for (int t = 0; t < 150; t++) begin
         logic [MVL-1:0] pm;
         if (t % 25 == 0) load_rf();
         pm = (t % 3 == 0) ? MVL'($urandom & $urandom) : MVL'($urandom);
         run_op("R3", int'($urandom_range(1, MVL)), int'($urandom_range(0, NREG - 1)),
                int'($urandom_range(0, NREG - 1)), int'($urandom_range(0, NREG - 1)),
                1'($urandom), 1'($urandom), 1'($urandom), pm, 1'($urandom), 0);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule